// File: doc/BRIEF.md
# Predictive Phase-Select TDC Combiner

This block is the digital back end of a short-range time-to-digital phase detector inside an all-digital PLL. It runs on the retimed reference clock. On every reference edge it adds a fractional frequency command word into a reference phase accumulator. From the accumulated fractional phase it predicts which of eight evenly spaced oscillator clock phases will lie nearest the next reference edge. It presents that choice on a three-bit select output. An external clock multiplexer steers the chosen phase into one short delay line, which covers only about one eighth of the oscillator period.

On the following edge the block receives the captured 12-stage pseudo-thermometer sample and decodes it to a fine code. It then tests the sample for saturation. It combines the predicted octant (weight 1/8 period) with the fine code, which is scaled by a programmable normalisation gain. It adds the integer oscillator phase count to that sum and subtracts the whole from the reference phase to form a fixed-point phase error.

A two-state sequencer keeps the error output quiet until the first usable sample arrives. The two states are `ST_WAIT` and `ST_TRACK`. A synchronous reset enters `ST_WAIT`. The transition `ST_WAIT -> ST_TRACK` happens on the first edge whose sample is not saturated. `ST_WAIT` stays in `ST_WAIT` while samples are saturated. `ST_TRACK` stays in `ST_TRACK` until the next reset. In `ST_TRACK` a saturated sample reuses the last good fine code.

Top module: `tdc_phase_combiner`

## Requirements
- R1: A synchronous reset clears the accumulator and zeroes `phase_sel`, `phase_err`, `tdc_sat` and `err_valid` after the edge where `rst` is sampled high.
- R2: On every edge with `rst` low, the accumulator adds `fcw`, read as an unsigned 8.16 value. The sum wraps modulo 2^32 in a 16.16 format.
- R3: After each edge, `phase_sel` equals accumulator bits [15:13], the top three fractional bits of the updated reference phase. It is the octant predicted for the next sample.
- R4: In `therm`, bit 0 is the first delay stage, and a 0 is implied beyond bit 11. The fine code is one plus the lowest index i where bit i is 1 and bit i+1 is 0, so it ranges from 1 to 12.
- R5: An all-zeros or all-ones sample is saturated, and the fine code from the last non-saturated sample is kept in its place.
- R6: In `ST_WAIT`, `phase_err` is 0 and `err_valid` is 0. The first non-saturated sample moves the block to `ST_TRACK`, and `err_valid` is 1 from that edge until reset.
- R7: In `ST_TRACK`, each edge loads `phase_err` (32-bit, 16.16 two's complement) with R - (V*2^16 + S*2^13 + F*G) mod 2^32. R and S are the accumulator and select values that held before the edge. V is `var_phase`, F is the fine code in use and G is `norm_gain`.
- R8: The fine correction is the product of the fine code and `norm_gain`, counted in units of 2^-16 of an oscillator period, so a gain of 0 removes it.
- R9: `tdc_sat` is registered each edge and is 1 exactly when the sample taken on that edge was saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retimed reference clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw | input | 24 | Frequency command word, unsigned 8.16 |
| therm | input | 12 | Pseudo-thermometer sample of the selected phase, bit 0 first stage |
| var_phase | input | 16 | Integer oscillator phase count at this edge |
| norm_gain | input | 16 | Unsigned normalisation gain for the fine code |
| phase_sel | output | 3 | Predicted oscillator phase for the next sample |
| phase_err | output | 32 | Signed 16.16 phase error |
| tdc_sat | output | 1 | Sample on the last edge was saturated |
| err_valid | output | 1 | Sequencer is in `ST_TRACK` |

## Verification
The assertions assume that `rst` is high on the first clock edge. They also assume that the fine code reaching the sequencer comes from the on-chip decoder, so a non-saturated sample always yields a code between 1 and 12. The stimulus holds reset for several edges at the start and once more in mid-run. It drives the 12-bit sample only through the decoder's port, and it mixes shifted thermometer runs, explicit all-zeros and all-ones samples, and fully random words. The frequency word, phase count and gain range over their whole widths, apart from one directed pass with a zero gain.

// File: rtl/tdc_comb_pkg.sv
package tdc_comb_pkg;

    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_t;

endpackage

// File: rtl/tdc_ref_accum.sv
module tdc_ref_accum #(
    parameter int FCW_INT = 8,
    parameter int FRAC_W  = 16,
    parameter int PH_INT  = 16,
    parameter int OCT_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [FCW_INT+FRAC_W-1:0]   fcw,
    output logic [PH_INT+FRAC_W-1:0]    acc_q,
    output logic [OCT_W-1:0]            sel_q
);
    localparam int FCW_W = FCW_INT + FRAC_W;
    localparam int PH_W  = PH_INT + FRAC_W;

    logic [PH_W-1:0] fcw_ext;
    logic [PH_W-1:0] acc_nx;

    assign fcw_ext = {{(PH_W-FCW_W){1'b0}}, fcw};
    assign acc_nx  = acc_q + fcw_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            sel_q <= '0;
        end else begin
            acc_q <= acc_nx;
            sel_q <= acc_nx[FRAC_W-1 -: OCT_W];
        end
    end

    // R2: accumulator advances by exactly the command word each edge
    assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (acc_q == $past(acc_q) + $past(fcw_ext)));

endmodule

// File: rtl/tdc_therm_decode.sv
module tdc_therm_decode #(
    parameter int STAGES = 12,
    parameter int CODE_W = $clog2(STAGES + 1)
) (
    input  logic [STAGES-1:0] therm,
    output logic [CODE_W-1:0] code,
    output logic              sat
);
    logic [STAGES:0]   ext;
    logic [STAGES-1:0] fall;
    logic              found;

    assign ext = {1'b0, therm};

    for (genvar g = 0; g < STAGES; g++) begin : g_fall
        assign fall[g] = ext[g] & ~ext[g+1];
    end

    always_comb begin
        code  = '0;
        found = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (!found && fall[i]) begin
                code  = CODE_W'(i + 1);
                found = 1'b1;
            end
        end
    end

    assign sat = (therm == '0) || (&therm);

endmodule

// File: rtl/tdc_err_core.sv
module tdc_err_core
    import tdc_comb_pkg::*;
#(
    parameter int FRAC_W = 16,
    parameter int PH_INT = 16,
    parameter int OCT_W  = 3,
    parameter int STAGES = 12,
    parameter int CODE_W = 4,
    parameter int GAIN_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [PH_INT+FRAC_W-1:0]    acc_q,
    input  logic [OCT_W-1:0]            sel_q,
    input  logic [PH_INT-1:0]           var_phase,
    input  logic [GAIN_W-1:0]           gain,
    input  logic [CODE_W-1:0]           code_in,
    input  logic                        sat_in,
    output logic signed [PH_INT+FRAC_W-1:0] phase_err,
    output logic                        tdc_sat,
    output logic                        err_valid
);
    localparam int PH_W   = PH_INT + FRAC_W;
    localparam int PROD_W = CODE_W + GAIN_W;

    trk_state_t state_q, state_nx;
    logic [CODE_W-1:0] fine_q;
    logic [CODE_W-1:0] fine_use;
    logic [PROD_W-1:0] prod;
    logic [PH_W-1:0]   corr;
    logic [PH_W-1:0]   err_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_WAIT:  if (!sat_in) state_nx = ST_TRACK;
            ST_TRACK: state_nx = ST_TRACK;
            default:  state_nx = ST_WAIT;
        endcase
    end

    assign fine_use = sat_in ? fine_q : code_in;
    assign prod     = fine_use * gain;
    assign corr     = {var_phase, {FRAC_W{1'b0}}}
                    + (PH_W'(sel_q) << (FRAC_W - OCT_W))
                    + PH_W'(prod);
    assign err_nx   = acc_q - corr;

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q    <= '0;
            phase_err <= '0;
            tdc_sat   <= 1'b0;
            err_valid <= 1'b0;
        end else begin
            tdc_sat <= sat_in;
            if (!sat_in) fine_q <= code_in;
            err_valid <= (state_nx == ST_TRACK);
            phase_err <= (state_nx == ST_TRACK) ? err_nx : '0;
        end
    end

    // R1: reset clears the visible outputs on the following edge
    assert_rst_clear_R1: assert property (@(posedge clk)
        rst |=> (phase_err == '0 && !err_valid && !tdc_sat));

    // R6: waiting state keeps the error silent
    assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (phase_err == '0 && !err_valid));

    // R5: saturated sample leaves the held fine code untouched
    assert_hold_on_sat_R5: assert property (@(posedge clk) disable iff (rst)
        sat_in |=> (fine_q == $past(fine_q)));

    // R4: an effective sample always decodes inside the stage range
    assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
        !sat_in |-> (code_in >= CODE_W'(1) && code_in <= CODE_W'(STAGES)));

endmodule

// File: rtl/tdc_phase_combiner.sv
module tdc_phase_combiner #(
    parameter int FCW_INT = 8,
    parameter int FRAC_W  = 16,
    parameter int PH_INT  = 16,
    parameter int OCT_W   = 3,
    parameter int STAGES  = 12,
    parameter int GAIN_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [FCW_INT+FRAC_W-1:0]       fcw,
    input  logic [STAGES-1:0]               therm,
    input  logic [PH_INT-1:0]               var_phase,
    input  logic [GAIN_W-1:0]               norm_gain,
    output logic [OCT_W-1:0]                phase_sel,
    output logic signed [PH_INT+FRAC_W-1:0] phase_err,
    output logic                            tdc_sat,
    output logic                            err_valid
);
    localparam int PH_W   = PH_INT + FRAC_W;
    localparam int CODE_W = $clog2(STAGES + 1);

    logic [PH_W-1:0]   acc_q;
    logic [OCT_W-1:0]  sel_q;
    logic [CODE_W-1:0] code;
    logic              sat;

    tdc_ref_accum #(
        .FCW_INT(FCW_INT), .FRAC_W(FRAC_W), .PH_INT(PH_INT), .OCT_W(OCT_W)
    ) u_accum (
        .clk(clk), .rst(rst), .fcw(fcw), .acc_q(acc_q), .sel_q(sel_q)
    );

    tdc_therm_decode #(
        .STAGES(STAGES), .CODE_W(CODE_W)
    ) u_decode (
        .therm(therm), .code(code), .sat(sat)
    );

    tdc_err_core #(
        .FRAC_W(FRAC_W), .PH_INT(PH_INT), .OCT_W(OCT_W),
        .STAGES(STAGES), .CODE_W(CODE_W), .GAIN_W(GAIN_W)
    ) u_core (
        .clk(clk), .rst(rst), .acc_q(acc_q), .sel_q(sel_q),
        .var_phase(var_phase), .gain(norm_gain),
        .code_in(code), .sat_in(sat),
        .phase_err(phase_err), .tdc_sat(tdc_sat), .err_valid(err_valid)
    );

    assign phase_sel = sel_q;

endmodule

// File: tb/tdc_phase_combiner_tb_top.sv
module tdc_phase_combiner_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] fcw = '0;
    logic [11:0] therm = '0;
    logic [15:0] var_phase = '0;
    logic [15:0] norm_gain = '0;
    logic [2:0]  phase_sel;
    logic signed [31:0] phase_err;
    logic        tdc_sat;
    logic        err_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // bench model
    logic [31:0] m_acc;
    logic [2:0]  m_sel;
    logic [3:0]  m_fine;
    logic        m_trk;
    logic [31:0] m_err;
    logic        m_sat;

    always #2.5 clk = ~clk;

    tdc_phase_combiner dut_i (
        .clk(clk), .rst(rst), .fcw(fcw), .therm(therm),
        .var_phase(var_phase), .norm_gain(norm_gain),
        .phase_sel(phase_sel), .phase_err(phase_err),
        .tdc_sat(tdc_sat), .err_valid(err_valid)
    );

    function automatic logic [3:0] exp_code(input logic [11:0] t);
        logic [12:0] e;
        e = {1'b0, t};
        exp_code = '0;
        for (int i = 11; i >= 0; i--)
            if (e[i] && !e[i+1]) exp_code = 4'(i + 1);
    endfunction

    function automatic logic exp_sat(input logic [11:0] t);
        return (t == 12'h000) || (t == 12'hFFF);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_acc = '0; m_sel = '0; m_fine = '0; m_trk = 0; m_err = '0; m_sat = 0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R7 phase_err"}, phase_err, m_err);
        chk("R2 R3 phase_sel", {29'b0, phase_sel}, {29'b0, m_sel});
        chk("R9 R5 tdc_sat", {31'b0, tdc_sat}, {31'b0, m_sat});
        chk("R6 err_valid", {31'b0, err_valid}, {31'b0, m_trk});
    endtask

    // drive at negedge, advance model, check at following negedge
    task automatic step(input logic [23:0] f, input logic [11:0] t,
                        input logic [15:0] vp, input logic [15:0] g,
                        input string tag);
        logic        s;
        logic [3:0]  c;
        logic [31:0] corr;
        fcw = f; therm = t; var_phase = vp; norm_gain = g;
        s = exp_sat(t);
        if (!s) begin
            m_fine = exp_code(t);
            m_trk  = 1;
        end
        corr  = {vp, 16'b0} + ({29'b0, m_sel} << 13) + ({28'b0, m_fine} * {16'b0, g});
        c     = m_fine;
        m_err = m_trk ? (m_acc - corr) : 32'h0;
        m_sat = s;
        m_acc = m_acc + {8'b0, f};
        m_sel = m_acc[15:13];
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
        if (c > 4'd12) $display("note: fine code out of range");
    endtask

    function automatic logic [11:0] rand_therm();
        int n, r, k;
        k = $urandom_range(0, 9);
        if (k == 0) return 12'h000;
        if (k == 1) return 12'hFFF;
        if (k == 2) return 12'($urandom);
        n = $urandom_range(1, 12);
        r = $urandom_range(0, 4);
        return 12'(12'hFFF >> (12 - n)) << r;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 phase_err", phase_err, 32'h0);
        chk("R1 phase_sel", {29'b0, phase_sel}, 32'h0);
        chk("R1 tdc_sat", {31'b0, tdc_sat}, 32'h0);
        chk("R1 err_valid", {31'b0, err_valid}, 32'h0);
        rst = 1'b0;

        // R6: saturated samples keep the sequencer waiting
        step(24'h32_4000, 12'h000, 16'd0, 16'd917, "R6 wait zeros");
        step(24'h32_4000, 12'hFFF, 16'd50, 16'd917, "R6 wait ones");
        // R4: decode patterns
        step(24'h32_4000, 12'b0000_0000_0001, 16'd100, 16'd917, "R4 code1");
        step(24'h32_4000, 12'b0111_1111_1111, 16'd150, 16'd917, "R4 code11");
        step(24'h32_4000, 12'b1111_1111_1110, 16'd200, 16'd917, "R4 code12");
        step(24'h32_4000, 12'b0000_1111_0011, 16'd250, 16'd917, "R4 code2");
        // R5: saturated sample in tracking reuses held code
        step(24'h32_4000, 12'hFFF, 16'd300, 16'd917, "R5 hold ones");
        step(24'h32_4000, 12'h000, 16'd350, 16'd917, "R5 hold zeros");
        // R8: zero gain removes fine term
        step(24'h32_4000, 12'b0000_0011_1111, 16'd400, 16'd0, "R8 gain0");
        step(24'h00_2000, 12'b0000_0000_0111, 16'd401, 16'hFFFF, "R8 gainmax");
        // R2 wrap: large word
        step(24'hFF_FFFF, 12'b0000_0000_0011, 16'hFFFF, 16'd917, "R2 wrap");

        for (int i = 0; i < 400; i++)
            step(24'($urandom), rand_therm(), 16'($urandom),
                 16'($urandom_range(0, 2047)), "R7 random");

        // R1: mid-run reset
        rst = 1'b1;
        fcw = 24'h12_3456; therm = 12'h00F;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1 midrun");

        for (int i = 0; i < 100; i++)
            step(24'($urandom), rand_therm(), 16'($urandom),
                 16'($urandom), "R7 R8 random2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule